// File: doc/BRIEF.md
# Flash Timing Clock Divider

This block derives the slow timing clock for an embedded flash array from the controller clock. The controller clock runs at half the system clock. The block is given that controller clock frequency in hertz as a 32-bit number. When `start` is pulsed, it samples the frequency and picks a divider setting made of two parts: a prescale flag that adds a fixed divide-by-8 stage, and a 6-bit divide value. The setting is chosen so that the timing clock is the fastest rate that does not exceed 200 kHz.

The division is done sequentially. A restoring shift-subtract divider runs for 32 cycles, so no combinational divider is needed. When the computation completes, the block raises `done` and presents the fields it latched. It also flags the setting as unusable in three cases: the frequency is zero, the divide value does not fit in 6 bits, or the resulting rate would drop below 150 kHz. A rate below that limit can damage the array. A rate above 200 kHz can leave programming or erasure incomplete. With a usable setting, the block emits a one-cycle enable pulse at the output rate and a square-wave timing clock.

Top module: `flash_tclk_div`

## Requirements
- R1: After synchronous active-high reset, `prescale`, `div`, `busy`, `done`, `err`, `tick` and `tclk` are all 0.
- R2: `prescale` is latched as 1 exactly when the sampled `in_hz` is greater than 12,800,000, and as 0 otherwise.
- R3: Let P be `in_hz` shifted right by 3 when prescale is set, and `in_hz` otherwise. Let Q be (P−1)/200000, computed as 32-bit unsigned integer division. `div` equals Q when Q ≤ 63 and saturates at 63 otherwise.
- R4: `err` is raised together with `done` when P is 0, when Q > 63, or when P < 150000·(div+1), which means the output rate is below 150 kHz. Otherwise `err` is 0.
- R5: A `start` accepted while idle raises `busy` on the next cycle and clears `done`. `done` rises no more than 40 cycles after the start. `busy` and `done` are never high together.
- R6: While `busy` is high, `start` and changes on `in_hz` are ignored, so the result reflects the frequency sampled by the accepted start.
- R7: When `done` is 1 and `err` is 0, `tick` is a one-cycle pulse with a period of N cycles, where N = (div+1)·8 if prescale is set and N = div+1 otherwise.
- R8: Within each period of N cycles, `tclk` is high for floor(N/2) cycles and low for the rest.
- R9: While `done` is 0 or `err` is 1, `tick` and `tclk` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new computation; ignored while busy |
| in_hz | input | 32 | Controller clock frequency in hertz, sampled on start |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Fields are valid |
| err | output | 1 | Setting is outside the safe band or is unrepresentable |
| prescale | output | 1 | Divide-by-8 prescale stage enabled |
| div | output | 6 | Divide value; the output rate is the prescaled rate / (div+1) |
| tick | output | 1 | One-cycle enable at the timing-clock rate |
| tclk | output | 1 | Square-wave timing clock |

## Verification
The hardest cases to reach are frequencies that sit right at the boundaries. The first is the prescale threshold and its neighbour above, where the 6-bit field just fits or just overflows. The second is a rate just below 150 kHz, which only occurs for narrow windows of input frequency. Directed values sit exactly on and next to these edges: 12.8 MHz, 102.4 MHz and +8 Hz beyond each, 290 kHz and 200,001 Hz. Seeded random frequencies up to about 110 MHz fill in the interior. For every usable result, the bench measures the tick period and the tclk high time against a model.

// File: rtl/flash_tclk_div.sv
module flash_tclk_div #(
  parameter int unsigned TARGET_HZ    = 200000,
  parameter int unsigned MIN_HZ       = 150000,
  parameter int unsigned PRE_LIMIT_HZ = 12800000,
  parameter int unsigned DIV_W        = 6,
  parameter int unsigned PRE_SHIFT    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [31:0]      in_hz,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             prescale,
  output logic [DIV_W-1:0] div,
  output logic             tick,
  output logic             tclk
);
  localparam int unsigned STEPS   = 32;
  localparam int unsigned DIV_MAX = (1 << DIV_W) - 1;
  localparam int unsigned CW      = DIV_W + PRE_SHIFT + 1;

  logic [31:0] rem, quo, p_hz, tmp, diff;
  logic [5:0]  step;
  logic        zero_in, ge, pre_w, ovf, slow;
  logic [31:0] p_w;
  logic [DIV_W-1:0] div_w;

  assign pre_w = in_hz > PRE_LIMIT_HZ;
  assign p_w   = pre_w ? (in_hz >> PRE_SHIFT) : in_hz;
  assign tmp   = {rem[30:0], quo[31]};
  assign ge    = tmp >= TARGET_HZ;
  assign diff  = tmp - TARGET_HZ;
  assign ovf   = |(quo >> DIV_W);
  assign div_w = ovf ? DIV_W'(DIV_MAX) : quo[DIV_W-1:0];
  assign slow  = {32'd0, p_hz} < 64'(MIN_HZ) * (64'(div_w) + 64'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; err <= 1'b0;
      prescale <= 1'b0; div <= '0;
      rem <= '0; quo <= '0; p_hz <= '0; step <= '0; zero_in <= 1'b0;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      done     <= 1'b0;
      err      <= 1'b0;
      prescale <= pre_w;
      p_hz     <= p_w;
      quo      <= p_w - 32'd1;
      zero_in  <= p_w == 32'd0;
      rem      <= '0;
      step     <= '0;
    end else if (busy) begin
      if (step != 6'(STEPS)) begin
        rem  <= ge ? diff : tmp;
        quo  <= {quo[30:0], ge};
        step <= step + 6'd1;
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
        div  <= div_w;
        err  <= zero_in | ovf | slow;
      end
    end
  end

  logic          run, last;
  logic [CW-1:0] cnt, period;

  assign run    = done & ~err;
  assign period = prescale ? (CW'(div) + CW'(1)) << PRE_SHIFT : CW'(div) + CW'(1);
  assign last   = cnt == period - CW'(1);
  assign tick   = run & last;
  assign tclk   = run & (cnt < (period >> 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= last ? '0 : cnt + CW'(1);
  end

  p_busy_done_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  p_start_accept_r5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done));
  p_fields_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(prescale));
  p_err_with_done_r4: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  p_tick_gated_r9: assert property (@(posedge clk) disable iff (rst)
    (tick || tclk) |-> (done && !err));
  p_tick_single_r7: assert property (@(posedge clk) disable iff (rst)
    (tick && period > CW'(1) && $past(run)) |=> !tick);
  p_div_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> $stable(div));
endmodule

// File: tb/tb_flash_tclk_div.sv
module tb_flash_tclk_div;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [31:0] in_hz = '0;
  logic busy, done, err, prescale, tick, tclk;
  logic [5:0] div;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  flash_tclk_div dut (.clk(clk), .rst(rst), .start(start), .in_hz(in_hz),
    .busy(busy), .done(done), .err(err), .prescale(prescale), .div(div),
    .tick(tick), .tclk(tclk));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic bit m_pre(input logic [31:0] f); return f > 32'd12800000; endfunction
  function automatic logic [31:0] m_p(input logic [31:0] f);
    return m_pre(f) ? f >> 3 : f;
  endfunction
  function automatic logic [31:0] m_q(input logic [31:0] f);
    logic [31:0] p1 = m_p(f) - 32'd1;
    return p1 / 32'd200000;
  endfunction
  function automatic int m_div(input logic [31:0] f);
    return m_q(f) > 63 ? 63 : int'(m_q(f));
  endfunction
  function automatic bit m_err(input logic [31:0] f);
    longint p = longint'(m_p(f));
    return p == 0 || m_q(f) > 63 || p < 150000 * (m_div(f) + 1);
  endfunction

  task automatic pulse_start;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
  endtask

  task automatic check_result(input logic [31:0] f, input int lat);
    int n, c, hi;
    chk(lat <= 40 && done, "R5 done latency", lat, 40);
    chk(prescale == m_pre(f), "R2 prescale", prescale, m_pre(f));
    chk(int'(div) == m_div(f), "R3 div", div, m_div(f));
    chk(err == m_err(f), "R4 err", err, m_err(f));
    if (!m_err(f)) begin
      n = (m_div(f) + 1) * (m_pre(f) ? 8 : 1);
      c = 0;
      while (!tick && c < 600) begin @(negedge clk); c++; end
      c = 0; hi = 0;
      do begin
        @(negedge clk); c++;
        if (tclk) hi++;
      end while (!tick && c < 600);
      chk(c == n, "R7 tick period", c, n);
      chk(hi == n / 2, "R8 tclk high time", hi, n / 2);
    end else begin
      c = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (tick || tclk) c++;
      end
      chk(c == 0, "R9 outputs quiet on error", c, 0);
    end
  endtask

  task automatic run_case(input logic [31:0] f);
    int lat;
    @(negedge clk) in_hz = f;
    pulse_start();
    chk(busy && !done, "R5 busy after start", {busy, done}, 2);
    wait_done(lat);
    check_result(f, lat);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] dir [14];
    int lat, q;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({prescale, div, busy, done, err, tick, tclk} == 0, "R1 reset state",
        {prescale, div, busy, done, err, tick, tclk}, 0);
    chk(!tick && !tclk, "R9 idle outputs", {tick, tclk}, 0);

    dir = '{32'd0, 32'd150000, 32'd200000, 32'd200001, 32'd290000, 32'd320000,
            32'd1000000, 32'd12800000, 32'd12800001, 32'd12800008, 32'd30000000,
            32'd102400000, 32'd102400008, 32'd4000000000};
    foreach (dir[i]) run_case(dir[i]);

    for (int i = 0; i < 40; i++) run_case(32'd100000 + ($urandom % 32'd110000000));

    // R6: second start and input change during busy are ignored
    @(negedge clk) in_hz = 32'd30000000;
    pulse_start();
    repeat (3) @(negedge clk);
    in_hz = 32'd450000;
    pulse_start();
    in_hz = 32'd777;
    wait_done(lat);
    chk(int'(div) == m_div(32'd30000000), "R6 busy start ignored", div, m_div(32'd30000000));
    check_result(32'd30000000, 10);

    // R5: restart after done clears done
    @(negedge clk) in_hz = 32'd1000000;
    pulse_start();
    chk(!done && busy, "R5 restart clears done", done, 0);
    wait_done(lat);
    q = m_div(32'd1000000);
    chk(int'(div) == q, "R3 div after restart", div, q);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule